// File: doc/BRIEF.md
# Hidden Region Overlay Controller

This block sits in front of a word-addressed non-volatile memory model. It serves reads and program requests from a strobe-based command bus. On request it swaps the lowest 128 words of the boot area for a separate hidden region of the same size. The lower half of that region holds factory data and is never writable. The upper half is for customer data and may be programmed until a one-way lock is applied. Programming can only clear bits. No operation erases the hidden region, and the lock is never undone.

Commands use an unlock prefix of three writes: key word one at the first unlock address, key word two at the second unlock address, then the command code at the first unlock address. The codes select overlay on, overlay off, lock, or program. For program, one more write carries the target address and the data.

The hardware reset pin is filtered by pulse width. An accepted reset aborts a pending program, clears the overlay and holds the data outputs disabled. After the pin is released, the block observes a recovery interval before it accepts reads again.

Both strobes are accepted only in a cycle where `ready_o` is high. A strobe in any other cycle is dropped. It is not queued, so the issuer must hold off until `ready_o` returns. Read data has no back-pressure: `rd_valid_o` is a one-cycle pulse, and the consumer must take the data in that cycle.

Top module: `hrom_overlay_ctrl`

## Requirements
- R1: After power-on reset or an accepted hardware reset, the overlay is off. A read of word address A below 512 returns the main array word, which starts as 0xA000 OR A.
- R2: After the enter sequence (0x00AA at 0x555, 0x0055 at 0x2AA, code 0x0088 at 0x555), reads at addresses 0x00–0x7F return the hidden region, and reads at 0x80 and above still return the main array. Factory words 0x00–0x3F start as 0xC000 OR A. Customer words 0x40–0x7F start as 0xFFFF.
- R3: The exit sequence, with code 0x0090, turns the overlay off, and reads at 0x00–0x7F return the main array again.
- R4: Any write that does not match the next expected step of the unlock prefix returns the decoder to idle, so that a sequence containing a wrong key has no effect.
- R5: The program sequence (code 0x00A0, then one write of address and data) stores the old word AND the written data. `ready_o` goes low for 8 cycles starting in the cycle after the data write, and the new value is readable once `ready_o` returns.
- R6: A program aimed at the factory half (0x00–0x3F with the overlay on) is rejected. `ready_o` stays high, and the word keeps its value.
- R7: The lock sequence (code 0x0060) permanently rejects programs to the customer half. The lock survives hardware reset and overlay exit, and a rejected program leaves `ready_o` high and the word unchanged.
- R8: Write and read strobes issued while `ready_o` is low are ignored. Such a read produces no `rd_valid_o`, and such a write does not advance or change any command state.
- R9: A hardware reset low pulse shorter than 4 consecutive cycles is ignored: the overlay and any pending program continue.
- R10: A reset held low for 4 cycles or more aborts a pending program, leaving the word unchanged, and clears the overlay. `data_oe_o` is low while the pin is low, and `ready_o` is low from acceptance on.
- R11: After an accepted reset is released, `ready_o` stays low for exactly 6 further cycles, and reads in that window are ignored.
- R12: A read accepted in a cycle raises `rd_valid_o` for exactly the following cycle, with the addressed word on `rd_data_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Power-on reset, active low, asynchronous |
| hwrst_ni | input | 1 | Hardware reset pin, active low, width-filtered |
| wr_stb_i | input | 1 | Write strobe for command or program data |
| rd_stb_i | input | 1 | Read strobe |
| addr_i | input | 12 | Word address |
| wdata_i | input | 16 | Write data |
| rd_valid_o | output | 1 | Read data valid, one-cycle pulse |
| rd_data_o | output | 16 | Read data |
| ready_o | output | 1 | High when strobes are accepted |
| data_oe_o | output | 1 | Data output drive enable |

## Verification
A wrong overlay or lock bit shows up at the first read of the low 128 words, or at the first program into the customer half. The read returns main instead of hidden contents, or a program is accepted when it should be rejected, which changes `ready_o` one cycle after the data write. A wrong reset-filter or recovery count shifts the edges of `ready_o` and `data_oe_o` by a cycle, and the model compares these on every clock. A corrupted program path shows up as a wrong AND result on the read that follows the busy window.

// File: rtl/hrom_pkg.sv
package hrom_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_KEY1 = 2'd1,
    SQ_KEY2 = 2'd2,
    SQ_DATA = 2'd3
  } seq_e;
endpackage

// File: rtl/hrom_rst_filter.sv
module hrom_rst_filter #(
  parameter int T_RP = 4,
  parameter int T_RH = 6
) (
  input  logic clk_i,
  input  logic por_ni,
  input  logic pin_ni,
  output logic hit_o,
  output logic in_rst_o,
  output logic rec_zero_o
);
  localparam int LW = $clog2(T_RP + 1);
  localparam int RW = $clog2(T_RH + 1);

  logic [LW-1:0] low_q;
  logic [RW-1:0] rec_q;
  logic          in_rst_q;

  // a reset is accepted on the edge that completes T_RP low samples
  assign hit_o      = !pin_ni && (low_q >= LW'(T_RP - 1));
  assign in_rst_o   = in_rst_q;
  assign rec_zero_o = (rec_q == '0);

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      low_q    <= '0;
      rec_q    <= '0;
      in_rst_q <= 1'b0;
    end else begin
      if (pin_ni)                  low_q <= '0;
      else if (low_q != LW'(T_RP)) low_q <= low_q + 1'b1;

      if (hit_o)                    rec_q <= '0;
      else if (in_rst_q && pin_ni)  rec_q <= RW'(T_RH);
      else if (rec_q != '0)         rec_q <= rec_q - 1'b1;

      if (hit_o)       in_rst_q <= 1'b1;
      else if (pin_ni) in_rst_q <= 1'b0;
    end
  end

  // R11: leaving reset always starts a full recovery window
  p_recovery_load_r11: assert property (@(posedge clk_i) disable iff (!por_ni)
    $fell(in_rst_q) |-> (rec_q == RW'(T_RH)));

  // R9/R10: reset state is only entered after a low sample
  p_entry_needs_low_r9: assert property (@(posedge clk_i) disable iff (!por_ni)
    $rose(in_rst_q) |-> $past(!pin_ni));
endmodule

// File: rtl/hrom_cmd_decode.sv
module hrom_cmd_decode
  import hrom_pkg::*;
#(
  parameter int             AW      = 12,
  parameter int             DW      = 16,
  parameter logic [AW-1:0]  A1      = 12'h555,
  parameter logic [AW-1:0]  A2      = 12'h2AA,
  parameter logic [DW-1:0]  KEY1    = 16'h00AA,
  parameter logic [DW-1:0]  KEY2    = 16'h0055,
  parameter logic [DW-1:0]  C_ENTER = 16'h0088,
  parameter logic [DW-1:0]  C_EXIT  = 16'h0090,
  parameter logic [DW-1:0]  C_PGM   = 16'h00A0,
  parameter logic [DW-1:0]  C_LOCK  = 16'h0060
) (
  input  logic          clk_i,
  input  logic          por_ni,
  input  logic          hit_i,
  input  logic          wr_go_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          overlay_o,
  output logic          lock_o,
  output logic          pgm_go_o
);
  seq_e seq_q;
  logic overlay_q;
  logic lock_q;

  assign overlay_o = overlay_q;
  assign lock_o    = lock_q;
  assign pgm_go_o  = wr_go_i && !hit_i && (seq_q == SQ_DATA);

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      seq_q     <= SQ_IDLE;
      overlay_q <= 1'b0;
      lock_q    <= 1'b0;
    end else if (hit_i) begin
      seq_q     <= SQ_IDLE;
      overlay_q <= 1'b0;
    end else if (wr_go_i) begin
      case (seq_q)
        SQ_IDLE: seq_q <= (addr_i == A1 && wdata_i == KEY1) ? SQ_KEY1 : SQ_IDLE;
        SQ_KEY1: seq_q <= (addr_i == A2 && wdata_i == KEY2) ? SQ_KEY2 : SQ_IDLE;
        SQ_KEY2: begin
          seq_q <= SQ_IDLE;
          if (addr_i == A1) begin
            if (wdata_i == C_ENTER)     overlay_q <= 1'b1;
            else if (wdata_i == C_EXIT) overlay_q <= 1'b0;
            else if (wdata_i == C_LOCK) lock_q    <= 1'b1;
            else if (wdata_i == C_PGM)  seq_q     <= SQ_DATA;
          end
        end
        default: seq_q <= SQ_IDLE;
      endcase
    end
  end

  // R10: accepted reset drops the overlay
  p_overlay_off_r10: assert property (@(posedge clk_i) disable iff (!por_ni)
    hit_i |=> !overlay_q);

  // R7: lock is one-way
  p_lock_sticky_r7: assert property (@(posedge clk_i) disable iff (!por_ni)
    lock_q |=> lock_q);
endmodule

// File: rtl/hrom_store.sv
module hrom_store #(
  parameter int AW         = 12,
  parameter int DW         = 16,
  parameter int MAIN_WORDS = 512,
  parameter int HID_WORDS  = 128,
  parameter int T_PGM      = 8
) (
  input  logic          clk_i,
  input  logic          por_ni,
  input  logic          hit_i,
  input  logic          overlay_i,
  input  logic          lock_i,
  input  logic          pgm_go_i,
  input  logic          rd_go_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          busy_o,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o
);
  localparam int HAW = $clog2(HID_WORDS);
  localparam int MAW = $clog2(MAIN_WORDS);
  localparam int BW  = $clog2(T_PGM + 1);
  localparam logic [AW-1:0] HID_LIM  = AW'(HID_WORDS);
  localparam logic [AW-1:0] HALF_LIM = AW'(HID_WORDS / 2);
  localparam logic [AW-1:0] MAIN_LIM = AW'(MAIN_WORDS);
  localparam logic [DW-1:0] MAIN_TAG = {4'hA, {(DW-4){1'b0}}};
  localparam logic [DW-1:0] FAC_TAG  = {4'hC, {(DW-4){1'b0}}};

  logic [DW-1:0] main_mem [MAIN_WORDS];
  logic [DW-1:0] hid_mem  [HID_WORDS];

  logic [BW-1:0] busy_q;
  logic [AW-1:0] p_addr_q;
  logic [DW-1:0] p_data_q;
  logic          p_hid_q;
  logic          rd_valid_q;
  logic [DW-1:0] rd_data_q;

  logic          tgt_hid;
  logic          allowed;
  logic          commit;
  logic          hid_we;
  logic          main_we;
  logic [DW-1:0] rd_word;

  assign tgt_hid = overlay_i && (addr_i < HID_LIM);
  assign allowed = tgt_hid ? (!lock_i && addr_i >= HALF_LIM) : (addr_i < MAIN_LIM);
  assign commit  = !hit_i && (busy_q == BW'(1));
  assign hid_we  = commit && p_hid_q;
  assign main_we = commit && !p_hid_q;
  assign busy_o  = (busy_q != '0);

  always_comb begin
    if (tgt_hid)                rd_word = hid_mem[addr_i[HAW-1:0]];
    else if (addr_i < MAIN_LIM) rd_word = main_mem[addr_i[MAW-1:0]];
    else                        rd_word = '1;
  end

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      busy_q     <= '0;
      p_addr_q   <= '0;
      p_data_q   <= '0;
      p_hid_q    <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else if (hit_i) begin
      busy_q     <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_go_i;
      if (rd_go_i) rd_data_q <= rd_word;
      if (busy_q != '0) busy_q <= busy_q - 1'b1;
      if (pgm_go_i && allowed) begin
        busy_q   <= BW'(T_PGM);
        p_addr_q <= addr_i;
        p_data_q <= wdata_i;
        p_hid_q  <= tgt_hid;
      end
    end
  end

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      for (int i = 0; i < MAIN_WORDS; i++) main_mem[i] <= MAIN_TAG | DW'(i);
    end else if (main_we) begin
      main_mem[p_addr_q[MAW-1:0]] <= main_mem[p_addr_q[MAW-1:0]] & p_data_q;
    end
  end

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      for (int i = 0; i < HID_WORDS; i++)
        hid_mem[i] <= (i < HID_WORDS / 2) ? (FAC_TAG | DW'(i)) : '1;
    end else if (hid_we) begin
      hid_mem[p_addr_q[HAW-1:0]] <= hid_mem[p_addr_q[HAW-1:0]] & p_data_q;
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;

  // R6/R7: hidden writes only reach the unlocked customer half
  p_hidden_gate_r6: assert property (@(posedge clk_i) disable iff (!por_ni)
    hid_we |-> (p_addr_q >= HALF_LIM) && !lock_i);

  // R10: accepted reset leaves no program pending
  p_abort_r10: assert property (@(posedge clk_i) disable iff (!por_ni)
    hit_i |=> (busy_q == '0));

  // R12: valid is a single-cycle pulse per accepted read
  p_valid_follows_read_r12: assert property (@(posedge clk_i) disable iff (!por_ni)
    rd_valid_q |-> $past(rd_go_i));
endmodule

// File: rtl/hrom_overlay_ctrl.sv
module hrom_overlay_ctrl #(
  parameter int             AW         = 12,
  parameter int             DW         = 16,
  parameter int             MAIN_WORDS = 512,
  parameter int             HID_WORDS  = 128,
  parameter int             T_RP       = 4,
  parameter int             T_RH       = 6,
  parameter int             T_PGM      = 8,
  parameter logic [AW-1:0]  A1         = 12'h555,
  parameter logic [AW-1:0]  A2         = 12'h2AA,
  parameter logic [DW-1:0]  KEY1       = 16'h00AA,
  parameter logic [DW-1:0]  KEY2       = 16'h0055,
  parameter logic [DW-1:0]  C_ENTER    = 16'h0088,
  parameter logic [DW-1:0]  C_EXIT     = 16'h0090,
  parameter logic [DW-1:0]  C_PGM      = 16'h00A0,
  parameter logic [DW-1:0]  C_LOCK     = 16'h0060
) (
  input  logic          clk_i,
  input  logic          por_ni,
  input  logic          hwrst_ni,
  input  logic          wr_stb_i,
  input  logic          rd_stb_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  output logic          ready_o,
  output logic          data_oe_o
);
  logic hit, in_rst, rec_zero;
  logic overlay, lock, pgm_go, busy;
  logic wr_go, rd_go;

  assign ready_o   = !in_rst && rec_zero && !busy;
  assign data_oe_o = hwrst_ni && !in_rst;
  assign wr_go     = wr_stb_i && ready_o;
  assign rd_go     = rd_stb_i && ready_o;

  hrom_rst_filter #(.T_RP(T_RP), .T_RH(T_RH)) u_filter (
    .clk_i      (clk_i),
    .por_ni     (por_ni),
    .pin_ni     (hwrst_ni),
    .hit_o      (hit),
    .in_rst_o   (in_rst),
    .rec_zero_o (rec_zero)
  );

  hrom_cmd_decode #(
    .AW(AW), .DW(DW), .A1(A1), .A2(A2), .KEY1(KEY1), .KEY2(KEY2),
    .C_ENTER(C_ENTER), .C_EXIT(C_EXIT), .C_PGM(C_PGM), .C_LOCK(C_LOCK)
  ) u_decode (
    .clk_i     (clk_i),
    .por_ni    (por_ni),
    .hit_i     (hit),
    .wr_go_i   (wr_go),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .overlay_o (overlay),
    .lock_o    (lock),
    .pgm_go_o  (pgm_go)
  );

  hrom_store #(
    .AW(AW), .DW(DW), .MAIN_WORDS(MAIN_WORDS), .HID_WORDS(HID_WORDS), .T_PGM(T_PGM)
  ) u_store (
    .clk_i      (clk_i),
    .por_ni     (por_ni),
    .hit_i      (hit),
    .overlay_i  (overlay),
    .lock_i     (lock),
    .pgm_go_i   (pgm_go),
    .rd_go_i    (rd_go),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .busy_o     (busy),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o)
  );

  // R8: no program can start while another is pending
  p_no_restart_r8: assert property (@(posedge clk_i) disable iff (!por_ni)
    busy |-> !pgm_go);

  // R10: outputs stay disabled while reset is held
  p_oe_off_held_r10: assert property (@(posedge clk_i) disable iff (!por_ni)
    (in_rst && !hwrst_ni) |-> !data_oe_o && !rd_valid_o);
endmodule

// File: tb/hrom_overlay_ctrl_tb.sv
module hrom_overlay_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int T_RP = 4;
  localparam int T_RH = 6;
  localparam int T_PGM = 8;
  localparam logic [11:0] A1 = 12'h555;
  localparam logic [11:0] A2 = 12'h2AA;
  localparam logic [15:0] K1 = 16'h00AA, K2 = 16'h0055;
  localparam logic [15:0] C_ENTER = 16'h0088, C_EXIT = 16'h0090;
  localparam logic [15:0] C_PGM = 16'h00A0, C_LOCK = 16'h0060;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        rst_pin_n = 1'b1;
  logic        wr_stb = 1'b0, rd_stb = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        rd_valid, ready, data_oe;
  logic [15:0] rd_data;

  int    vectors = 0;
  int    fails = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  hrom_overlay_ctrl u_dut (
    .clk_i(clk), .por_ni(por_n), .hwrst_ni(rst_pin_n),
    .wr_stb_i(wr_stb), .rd_stb_i(rd_stb), .addr_i(addr), .wdata_i(wdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .ready_o(ready), .data_oe_o(data_oe)
  );

  // ---------------- behavioural reference model ----------------
  int m_low, m_rec, m_busy, m_seq, m_paddr;
  bit m_inrst, m_ov, m_lock, m_phid, m_rdv;
  logic [15:0] m_rdd, m_pdata;
  logic [15:0] m_hid [128];
  logic [15:0] m_main [512];

  function automatic logic [15:0] m_look(int a);
    if (m_ov && a < 128) return m_hid[a];
    if (a < 512) return m_main[a];
    return 16'hFFFF;
  endfunction

  task automatic m_init();
    m_low = 0; m_rec = 0; m_busy = 0; m_seq = 0; m_paddr = 0;
    m_inrst = 0; m_ov = 0; m_lock = 0; m_phid = 0; m_rdv = 0;
    m_rdd = '0; m_pdata = '0;
    for (int i = 0; i < 512; i++) m_main[i] = 16'hA000 | 16'(i);
    for (int i = 0; i < 128; i++) m_hid[i] = (i < 64) ? (16'hC000 | 16'(i)) : 16'hFFFF;
  endtask

  initial m_init();

  always @(posedge clk) begin
    if (!por_n) m_init();
    else begin
      bit hit, rdy, tgt, ok;
      int a;
      a   = int'(addr);
      hit = !rst_pin_n && (m_low >= T_RP - 1);
      rdy = !m_inrst && m_rec == 0 && m_busy == 0;
      if (hit) m_rec = 0;
      else if (m_inrst && rst_pin_n) m_rec = T_RH;
      else if (m_rec > 0) m_rec--;
      if (hit) m_inrst = 1;
      else if (rst_pin_n) m_inrst = 0;
      m_low = rst_pin_n ? 0 : ((m_low < T_RP) ? m_low + 1 : T_RP);
      if (hit) begin
        m_busy = 0; m_seq = 0; m_ov = 0; m_rdv = 0;
      end else begin
        m_rdv = rd_stb && rdy;
        if (m_rdv) m_rdd = m_look(a);
        if (m_busy > 0) begin
          if (m_busy == 1) begin
            if (m_phid) m_hid[m_paddr] = m_hid[m_paddr] & m_pdata;
            else        m_main[m_paddr] = m_main[m_paddr] & m_pdata;
          end
          m_busy--;
        end
        if (wr_stb && rdy) begin
          case (m_seq)
            0: m_seq = (addr == A1 && wdata == K1) ? 1 : 0;
            1: m_seq = (addr == A2 && wdata == K2) ? 2 : 0;
            2: begin
              m_seq = 0;
              if (addr == A1) begin
                if (wdata == C_ENTER) m_ov = 1;
                else if (wdata == C_EXIT) m_ov = 0;
                else if (wdata == C_LOCK) m_lock = 1;
                else if (wdata == C_PGM) m_seq = 3;
              end
            end
            default: begin
              tgt = m_ov && a < 128;
              ok  = tgt ? (!m_lock && a >= 64) : (a < 512);
              if (ok) begin
                m_busy = T_PGM; m_paddr = a; m_pdata = wdata; m_phid = tgt;
              end
              m_seq = 0;
            end
          endcase
        end
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (por_n) begin
      bit mr, mo;
      mr = !m_inrst && m_rec == 0 && m_busy == 0;
      mo = rst_pin_n && !m_inrst;
      vectors++;
      if (ready !== mr || data_oe !== mo || rd_valid !== m_rdv ||
          (m_rdv && rd_data !== m_rdd)) begin
        fails++;
        $display("FAIL %s model: actual rdy=%b oe=%b v=%b d=%h expected rdy=%b oe=%b v=%b d=%h",
                 cur_req, ready, data_oe, rd_valid, rd_data, mr, mo, m_rdv, m_rdd);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc();
    @(negedge clk); #1;
  endtask

  task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [15:0] d);
    wr_stb = 1'b1; addr = a; wdata = d;
    cyc();
    wr_stb = 1'b0;
  endtask

  task automatic cmd(logic [15:0] code);
    wr(A1, K1); wr(A2, K2); wr(A1, code);
  endtask

  task automatic rd_chk(logic [11:0] a, logic [15:0] exp, string tag);
    rd_stb = 1'b1; addr = a;
    cyc();
    rd_stb = 1'b0;
    chk(rd_valid === 1'b1 && rd_data === exp, tag, rd_data, exp);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 50 && !ready; i++) cyc();
  endtask

  task automatic hw_reset(int lows);
    rst_pin_n = 1'b0;
    repeat (lows) cyc();
    rst_pin_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL all: watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    por_n = 1'b1;
    cyc();
    // R1 reset state and main contents
    cur_req = "R1";
    chk(ready === 1'b1 && data_oe === 1'b1 && rd_valid === 1'b0, "R1 reset outputs",
        {13'b0, ready, data_oe, rd_valid}, 16'h0006);
    rd_chk(12'h005, 16'hA005, "R1 main low");
    rd_chk(12'h07F, 16'hA07F, "R1 main top of window");
    // R12 valid lasts one cycle
    cur_req = "R12";
    cyc();
    chk(rd_valid === 1'b0, "R12 valid single pulse", {15'b0, rd_valid}, 16'h0000);

    // R2 overlay on
    cur_req = "R2";
    cmd(C_ENTER);
    rd_chk(12'h005, 16'hC005, "R2 factory word");
    rd_chk(12'h045, 16'hFFFF, "R2 customer erased");
    rd_chk(12'h080, 16'hA080, "R2 outside window");

    // R5 program with AND and busy window
    cur_req = "R5";
    cmd(C_PGM); wr(12'h045, 16'h0F3C);
    chk(ready === 1'b0, "R5 busy after data", {15'b0, ready}, 16'h0000);
    wait_ready();
    rd_chk(12'h045, 16'h0F3C, "R5 first program");
    cmd(C_PGM); wr(12'h045, 16'hFF00);
    wait_ready();
    rd_chk(12'h045, 16'h0F00, "R5 AND with old");

    // R6 factory half rejected
    cur_req = "R6";
    cmd(C_PGM); wr(12'h005, 16'h0000);
    chk(ready === 1'b1, "R6 no busy on factory", {15'b0, ready}, 16'h0001);
    rd_chk(12'h005, 16'hC005, "R6 factory unchanged");

    // R8 strobes during busy ignored
    cur_req = "R8";
    cmd(C_PGM); wr(12'h046, 16'h1234);
    rd_stb = 1'b1; addr = 12'h005;
    cyc();
    rd_stb = 1'b0;
    chk(rd_valid === 1'b0, "R8 read in busy dropped", {15'b0, rd_valid}, 16'h0000);
    wr(A1, K1); wr(A2, K2); wr(A1, C_EXIT);
    wait_ready();
    rd_chk(12'h046, 16'h1234, "R8 program landed");
    rd_chk(12'h005, 16'hC005, "R8 exit during busy ignored");

    // R4 wrong key aborts sequence
    cur_req = "R4";
    wr(A1, K1); wr(A2, 16'h0056); wr(A1, C_EXIT);
    rd_chk(12'h005, 16'hC005, "R4 bad key no exit");

    // R3 exit
    cur_req = "R3";
    cmd(C_EXIT);
    rd_chk(12'h005, 16'hA005, "R3 main again");
    cur_req = "R5";
    cmd(C_PGM); wr(12'h010, 16'h00F0);
    wait_ready();
    rd_chk(12'h010, 16'h0010, "R5 main program");

    // R9 short pulse ignored
    cur_req = "R9";
    cmd(C_ENTER);
    rst_pin_n = 1'b0;
    cyc();
    chk(data_oe === 1'b0, "R10 oe low with pin low", {15'b0, data_oe}, 16'h0000);
    repeat (T_RP - 2) cyc();
    rst_pin_n = 1'b1;
    cyc();
    chk(ready === 1'b1, "R9 no recovery", {15'b0, ready}, 16'h0001);
    rd_chk(12'h005, 16'hC005, "R9 overlay kept");

    // R10 accepted reset aborts program
    cur_req = "R10";
    cmd(C_PGM); wr(12'h047, 16'h0000);
    rst_pin_n = 1'b0;
    repeat (T_RP + 2) cyc();
    chk(data_oe === 1'b0 && ready === 1'b0, "R10 held outputs",
        {14'b0, data_oe, ready}, 16'h0000);
    rst_pin_n = 1'b1;
    // R11 recovery length
    cur_req = "R11";
    begin
      int cnt;
      cnt = 0;
      rd_stb = 1'b1; addr = 12'h005;
      for (int i = 0; i < 40; i++) begin
        cyc();
        rd_stb = 1'b0;
        if (i == 1)
          chk(rd_valid === 1'b0, "R11 read in recovery", {15'b0, rd_valid}, 16'h0000);
        if (ready) break;
        cnt++;
      end
      chk(cnt == T_RH, "R11 recovery cycles", 16'(cnt), 16'(T_RH));
    end
    cur_req = "R10";
    rd_chk(12'h047, 16'hA047, "R10 overlay cleared");
    cmd(C_ENTER);
    rd_chk(12'h047, 16'hFFFF, "R10 aborted program");

    // R7 lock is permanent
    cur_req = "R7";
    cmd(C_LOCK);
    cmd(C_PGM); wr(12'h048, 16'h0000);
    chk(ready === 1'b1, "R7 locked no busy", {15'b0, ready}, 16'h0001);
    rd_chk(12'h048, 16'hFFFF, "R7 locked unchanged");
    hw_reset(T_RP + 1);
    wait_ready();
    cmd(C_ENTER);
    cmd(C_PGM); wr(12'h048, 16'h0000);
    chk(ready === 1'b1, "R7 lock survives reset", {15'b0, ready}, 16'h0001);
    rd_chk(12'h048, 16'hFFFF, "R7 still unchanged");
    rd_chk(12'h046, 16'h1234, "R7 earlier data kept");

    cyc();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule